// File: doc/BRIEF.md
# Hash Engine Interrupt Aggregator

This block gathers the interrupt events of a hash engine and of the DMA unit that feeds it into one interrupt line. Each side has its own bank: a sticky status register that event pulses set, and an enable register that picks which status bits may raise the line. The DMA bank also has a single global mask bit. Software clears pending status bits by writing ones to them. The block also drives two group lines, one for error causes and one for completion causes. An interrupt handler can use them to decide what to do before it reads any register.

Software reaches the registers through a simple write strobe port and a combinational read port. The interrupt outputs are registered levels. They follow the status and enable state with one cycle of delay.

Top module: `irq_agg`

## Requirements
- R1: After reset all status bits, both enable registers and the DMA mask bit are zero, and irqOut, errIrq and doneIrq are low.
- R2: A one on an implemented bit of engEvt (4 bits; bit 2 is hash done, bits 0, 1 and 3 are errors) sets the matching engine status bit on the next clock edge. The bit stays set after the pulse ends.
- R3: Writing to a status register clears each bit written as one and leaves each bit written as zero unchanged. Writing all ones clears every pending bit of that bank.
- R4: When an event sets a status bit in the same cycle that software clears it, the bit stays set. Other bits cleared in that write are still cleared.
- R5: irqOut is a registered level. It is high one cycle after any engine bit that is both set and enabled, or any DMA bit that is set and enabled while the mask bit is 1. It falls one cycle after the last such bit goes away.
- R6: DMA events (9 bits; bit 0 is source transfer done, bits 2 to 8 are errors, bit 1 is reserved) set the DMA status bits. DMA status reaches the outputs only while the mask bit (bit 0 of the mask register) is 1. Bit 1 of the DMA status and enable registers never sets and reads zero.
- R7: With an enable register written to zero, that bank's events still set status but do not raise irqOut.
- R8: errIrq is high one cycle after any enabled, unmasked error bit is set. doneIrq is high one cycle after an enabled, unmasked done bit (engine bit 2, DMA bit 0) is set.
- R9: The register map is: engine status at 0x050, engine enable at 0x054, DMA status at 0x480, DMA enable at 0x484, DMA mask at 0x488. Any other address reads zero, and unimplemented bits read zero.
- R10: A write to any unmapped address changes no register. Enable writes keep only the implemented bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Write byte address |
| wrData | input | 9 | Write data (widest bank width) |
| rdAddr | input | 12 | Read byte address |
| rdData | output | 32 | Read data, zero-extended, combinational |
| engEvt | input | 4 | Hash engine event pulses |
| dmaEvt | input | 9 | DMA event pulses |
| irqOut | output | 1 | Combined interrupt level |
| errIrq | output | 1 | Enabled error cause pending |
| doneIrq | output | 1 | Enabled completion cause pending |

## Verification
The hardest case to reach from the ports is a collision: an event pulse and a clear write that hit the same status bit on the same clock edge. The stimulus drives engEvt and the write strobe from the same falling edge. The write covers the colliding bit and one other pending bit, so the bench can see the set win and the clear still act on the other bit. The registered output delay is checked on both the rising and the falling side. The mask bit is toggled while DMA status is pending, which shows that the mask gates the outputs and leaves the status untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Write strobes from the decoder to the register datapath
  typedef struct packed {
    logic engClr;
    logic engEnWr;
    logic dmaClr;
    logic dmaEnWr;
    logic maskWr;
  } wrStb_t;

  typedef enum logic [2:0] {
    RD_NONE   = 3'd0,
    RD_ENG_ST = 3'd1,
    RD_ENG_EN = 3'd2,
    RD_DMA_ST = 3'd3,
    RD_DMA_EN = 3'd4,
    RD_MASK   = 3'd5
  } rdSel_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_ENG_ST = 12'h050,
  parameter logic [ADDR_W-1:0] OFS_ENG_EN = 12'h054,
  parameter logic [ADDR_W-1:0] OFS_DMA_ST = 12'h480,
  parameter logic [ADDR_W-1:0] OFS_DMA_EN = 12'h484,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 12'h488
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output wrStb_t            stb,
  output rdSel_t            rdSel
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (wrAddr)
        OFS_ENG_ST: stb.engClr  = 1'b1;
        OFS_ENG_EN: stb.engEnWr = 1'b1;
        OFS_DMA_ST: stb.dmaClr  = 1'b1;
        OFS_DMA_EN: stb.dmaEnWr = 1'b1;
        OFS_MASK:   stb.maskWr  = 1'b1;
        default:    stb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (rdAddr)
      OFS_ENG_ST: rdSel = RD_ENG_ST;
      OFS_ENG_EN: rdSel = RD_ENG_EN;
      OFS_DMA_ST: rdSel = RD_DMA_ST;
      OFS_DMA_EN: rdSel = RD_DMA_EN;
      OFS_MASK:   rdSel = RD_MASK;
      default:    rdSel = RD_NONE;
    endcase
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R9

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb == '0)); // R10

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ENG_W  = 4,
  parameter int DMA_W  = 9,
  parameter logic [ENG_W-1:0] ENG_DONE = 4'b0100,
  parameter logic [ENG_W-1:0] ENG_ERR  = 4'b1011,
  parameter logic [DMA_W-1:0] DMA_DONE = 9'h001,
  parameter logic [DMA_W-1:0] DMA_ERR  = 9'h1FC
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStb_t            stb,
  input  rdSel_t            rdSel,
  input  logic [DMA_W-1:0]  wrData,
  input  logic [ENG_W-1:0]  engEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              errIrq,
  output logic              doneIrq
);

  localparam logic [ENG_W-1:0] ENG_IMPL = ENG_DONE | ENG_ERR;
  localparam logic [DMA_W-1:0] DMA_IMPL = DMA_DONE | DMA_ERR;

  logic [ENG_W-1:0] engSt, engEn, engClrMask, engAct;
  logic [DMA_W-1:0] dmaSt, dmaEn, dmaClrMask, dmaAct;
  logic             maskBit;
  logic             irqQ, errQ, doneQ;

  assign engClrMask = stb.engClr ? wrData[ENG_W-1:0] : '0;
  assign dmaClrMask = stb.dmaClr ? wrData : '0;

  // Status banks: an event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      engSt <= '0;
      dmaSt <= '0;
    end else begin
      engSt <= (engSt & ~engClrMask) | (engEvt & ENG_IMPL);
      dmaSt <= (dmaSt & ~dmaClrMask) | (dmaEvt & DMA_IMPL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engEn   <= '0;
      dmaEn   <= '0;
      maskBit <= 1'b0;
    end else begin
      if (stb.engEnWr) engEn   <= wrData[ENG_W-1:0] & ENG_IMPL;
      if (stb.dmaEnWr) dmaEn   <= wrData & DMA_IMPL;
      if (stb.maskWr)  maskBit <= wrData[0];
    end
  end

  assign engAct = engSt & engEn;
  assign dmaAct = dmaSt & dmaEn & {DMA_W{maskBit}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ  <= 1'b0;
      errQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      irqQ  <= (|engAct) | (|dmaAct);
      errQ  <= (|(engAct & ENG_ERR)) | (|(dmaAct & DMA_ERR));
      doneQ <= (|(engAct & ENG_DONE)) | (|(dmaAct & DMA_DONE));
    end
  end

  assign irqOut  = irqQ;
  assign errIrq  = errQ;
  assign doneIrq = doneQ;

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_ENG_ST: rdData[ENG_W-1:0] = engSt;
      RD_ENG_EN: rdData[ENG_W-1:0] = engEn;
      RD_DMA_ST: rdData[DMA_W-1:0] = dmaSt;
      RD_DMA_EN: rdData[DMA_W-1:0] = dmaEn;
      RD_MASK:   rdData[0]         = maskBit;
      default:   rdData = '0;
    endcase
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((engSt & $past(engSt & ~engClrMask)) == $past(engSt & ~engClrMask))); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|engEvt) |=> ((engSt & $past(engEvt)) == $past(engEvt))); // R4

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (engEn == '0 && !maskBit) |=> !irqOut); // R6

  AST_GROUPS_COVER: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (errIrq || doneIrq)); // R8

  AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((dmaSt | dmaEn) & ~DMA_IMPL) == '0); // R6

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ENG_W  = 4,
  parameter int DMA_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DMA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ENG_W-1:0]  engEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  output logic              irqOut,
  output logic              errIrq,
  output logic              doneIrq
);

  wrStb_t stb;
  rdSel_t rdSel;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  irq_agg_dp #(
    .DATA_W (DATA_W),
    .ENG_W  (ENG_W),
    .DMA_W  (DMA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .engEvt  (engEvt),
    .dmaEvt  (dmaEvt),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .errIrq  (errIrq),
    .doneIrq (doneIrq)
  );

endmodule

// File: tb/irq_agg_tb_top.sv
module irq_agg_tb_top;

  localparam logic [11:0] A_ENG_ST = 12'h050;
  localparam logic [11:0] A_ENG_EN = 12'h054;
  localparam logic [11:0] A_DMA_ST = 12'h480;
  localparam logic [11:0] A_DMA_EN = 12'h484;
  localparam logic [11:0] A_MASK   = 12'h488;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [8:0]  wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  engEvt = '0;
  logic [8:0]  dmaEvt = '0;
  logic        irqOut, errIrq, doneIrq;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;

  typedef struct {
    string tag;
    int    sel;
    logic [31:0] exp;
  } expItem_t;

  expItem_t expQ[$];

  irq_agg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .engEvt(engEvt), .dmaEvt(dmaEvt),
    .irqOut(irqOut), .errIrq(errIrq), .doneIrq(doneIrq)
  );

  always #2 clk = ~clk;

  // Monitor: pops expectations and compares after the falling edge
  always @(negedge clk) begin
    #1;
    while (expQ.size() > 0) begin
      expItem_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      case (it.sel)
        0: act = {31'b0, irqOut};
        1: act = {31'b0, errIrq};
        2: act = {31'b0, doneIrq};
        default: act = rdData;
      endcase
      testCnt++;
      if (act !== it.exp) begin
        failCnt++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pushExp(string tag, int sel, logic [31:0] exp);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
  endtask

  task automatic expRd(string tag, logic [11:0] a, logic [31:0] exp);
    rdAddr = a;
    pushExp(tag, 3, exp);
    tick();
  endtask

  task automatic expOuts(string tag, logic irq, logic err, logic done);
    pushExp({tag, " irq"}, 0, {31'b0, irq});
    pushExp({tag, " err"}, 1, {31'b0, err});
    pushExp({tag, " done"}, 2, {31'b0, done});
    tick();
  endtask

  task automatic wr(logic [11:0] a, logic [8:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic engPulse(logic [3:0] v);
    engEvt = v;
    tick();
    engEvt = '0;
  endtask

  task automatic dmaPulse(logic [8:0] v);
    dmaEvt = v;
    tick();
    dmaEvt = '0;
  endtask

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    expOuts("R1 reset", 1'b0, 1'b0, 1'b0);
    expRd("R1 eng status", A_ENG_ST, 32'h0);
    expRd("R1 dma status", A_DMA_ST, 32'h0);
    expRd("R1 mask", A_MASK, 32'h0);

    // R2 event sets sticky bit; R7 disabled bank keeps line low
    engPulse(4'b0100);
    tick();
    expRd("R2 sticky done bit", A_ENG_ST, 32'h4);
    expOuts("R7 engine disabled", 1'b0, 1'b0, 1'b0);

    // R5 enabling raises line one cycle later; R8 done group
    wr(A_ENG_EN, 9'h1FF);
    expOuts("R5 before delay", 1'b0, 1'b0, 1'b0);
    expOuts("R8 done group", 1'b1, 1'b0, 1'b1);
    expRd("R10 engine enable implemented bits", A_ENG_EN, 32'hF);

    // R3 zeros written leave bits unchanged
    wr(A_ENG_ST, 9'h1F0);
    expRd("R3 zero write keeps", A_ENG_ST, 32'h4);

    // R8 error group
    engPulse(4'b0001);
    tick();
    expOuts("R8 error group", 1'b1, 1'b1, 1'b1);
    expRd("R2 two bits pending", A_ENG_ST, 32'h5);
    wr(A_ENG_ST, 9'h001);
    expRd("R3 clear one bit", A_ENG_ST, 32'h4);
    expOuts("R8 error gone", 1'b1, 1'b0, 1'b1);

    // R4 set wins over same-cycle clear; other cleared bit goes
    engEvt = 4'b1000;
    wr(A_ENG_ST, 9'h00C);
    engEvt = '0;
    expRd("R4 set wins", A_ENG_ST, 32'h8);

    // R3 all ones clears; R5 falls one cycle later
    tick();
    wr(A_ENG_ST, 9'h1FF);
    pushExp("R3 all ones clear", 3, 32'h0);
    rdAddr = A_ENG_ST;
    pushExp("R5 still high", 0, 32'h1);
    tick();
    expOuts("R5 falls", 1'b0, 1'b0, 1'b0);

    // R7 enable write zero
    wr(A_ENG_EN, 9'h000);
    engPulse(4'b1111);
    tick();
    expOuts("R7 enable zero", 1'b0, 1'b0, 1'b0);
    expRd("R7 status still set", A_ENG_ST, 32'hF);
    wr(A_ENG_ST, 9'h1FF);

    // R6 DMA bank
    wr(A_DMA_EN, 9'h1FF);
    expRd("R6 dma enable reserved bit", A_DMA_EN, 32'h1FD);
    dmaPulse(9'h1FF);
    tick();
    expRd("R6 dma status reserved bit", A_DMA_ST, 32'h1FD);
    expOuts("R6 mask off", 1'b0, 1'b0, 1'b0);
    wr(A_MASK, 9'h001);
    expRd("R9 mask readback", A_MASK, 32'h1);
    expOuts("R6 mask on", 1'b1, 1'b1, 1'b1);
    wr(A_DMA_ST, 9'h1FC);
    tick();
    expOuts("R8 dma done only", 1'b1, 1'b0, 1'b1);
    wr(A_MASK, 9'h000);
    tick();
    expOuts("R6 mask off again", 1'b0, 1'b0, 1'b0);
    expRd("R6 status kept under mask", A_DMA_ST, 32'h1);

    // R7 DMA enable zero with mask on
    wr(A_MASK, 9'h001);
    wr(A_DMA_EN, 9'h000);
    tick();
    expOuts("R7 dma enable zero", 1'b0, 1'b0, 1'b0);

    // R9 unmapped read; R10 unmapped write
    wr(A_DMA_EN, 9'h001);
    wr(12'h058, 9'h1FF);
    wr(12'h100, 9'h000);
    expRd("R9 unmapped read", 12'h100, 32'h0);
    expRd("R10 dma status untouched", A_DMA_ST, 32'h1);
    expRd("R10 dma enable untouched", A_DMA_EN, 32'h1);
    expRd("R10 mask untouched", A_MASK, 32'h1);

    tick(); tick();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule